// File: doc/BRIEF.md
# Single-Precision Compare to Condition Flags

This block compares two packed IEEE-754 single-precision words, a first operand `op_d` and a second operand `op_m`. It reduces the result to four condition flags and an invalid-operation flag. Every outcome has its own flag combination:

- equal sets Z and C;
- less-than sets N alone;
- greater-than sets C alone;
- unordered sets C and V.

Ordering is worked out on the raw bit patterns. Each word is read as a sign bit followed by a magnitude integer. The magnitude order is reversed when both operands are negative.

Two control inputs pick the variant.

- `quiet_traps` makes quiet NaNs raise invalid as well as signalling ones.
- `cmp_zero` replaces the second operand with positive zero. This gives compare-with-zero in either the quiet or the trapping flavour.

The comparison logic is combinational. The flags are captured in one output register, so a result appears on the clock edge after its operands are presented.

Top module: `fcmp_nzcv`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all five outputs are 0 after that edge (synchronous, active-low reset).
- R2: Outputs change only at a rising edge and show the comparison of the inputs sampled at that edge, so the latency is one cycle.
- R3: A word is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is a NaN, the result is unordered: N=0, Z=0, C=1, V=1.
- R4: A NaN whose bit 22 is 0 is signalling. A signalling NaN in either operand sets `invalid` in both modes.
- R5: A quiet NaN (bit 22 is 1) sets `invalid` only when `quiet_traps` is 1.
- R6: When neither operand is a NaN, `invalid` and V are 0.
- R7: With no NaN, operands that are bit-identical, or both zero whatever their signs, give Z=1, C=1, N=0, V=0.
- R8: With no NaN and different sign bits (bit 31), and not both zero, the result is N alone when `op_d` is negative and C alone when `op_d` is positive.
- R9: With no NaN, equal signs and unequal words, bits 30:0 are compared as unsigned integers. For positive operands the smaller integer is the lesser operand. For negative operands the larger integer is the lesser operand. The result is N alone for less and C alone for greater.
- R10: Infinities (exponent all ones, mantissa zero) need no special case. +inf is above every finite positive value and -inf is below every finite negative value.
- R11: When `cmp_zero` is 1, `op_m` is ignored and +0 (all bits zero) is compared in its place, in both `quiet_traps` modes.
- R12: After reset, the flag group {N,Z,C,V} is always exactly one of 0110, 1000, 0010 or 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_d | input | 32 | First operand, packed single precision |
| op_m | input | 32 | Second operand, packed single precision |
| quiet_traps | input | 1 | 1: quiet NaNs also raise invalid |
| cmp_zero | input | 1 | 1: compare `op_d` against +0 instead of `op_m` |
| flag_n | output | 1 | Negative flag (less than) |
| flag_z | output | 1 | Zero flag (equal) |
| flag_c | output | 1 | Carry flag (equal, greater or unordered) |
| flag_v | output | 1 | Overflow flag (unordered) |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench aims at the signed-zero rule. A design that compares bits without that rule would call +0 and -0 ordered by sign and give N or C instead of ZC.

It pairs negative operands in both directions. A missing reversal of the magnitude order for negatives would swap N and C there.

It puts NaNs with bit 22 set and clear into each operand, under both trap settings. This exposes a design that traps on quiet NaNs by default, misses signalling ones, or checks only one operand.

Finally, it feeds a NaN or a large value on `op_m` while `cmp_zero` is set. A design that lets the ignored operand through would report unordered, or the wrong order, against zero.

// File: rtl/fcmp_pkg.sv
// Shared types and flag encodings for the single-precision comparator.
// Assumes flags are ordered {N,Z,C,V} from most to least significant.
package fcmp_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t FLG_EQUAL   = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
    localparam nzcv_t FLG_LESS    = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
    localparam nzcv_t FLG_GREATER = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
    localparam nzcv_t FLG_UNORD   = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};

endpackage

// File: rtl/fcmp_class.sv
// Classifies one packed floating-point word as NaN and, if so, as signalling.
// Assumes the layout {sign, exponent[EXP_W], mantissa[MAN_W]}; the quiet
// marker is the top mantissa bit.
module fcmp_class #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_nan,
    output logic              is_snan
);

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    assign expo = word[WORD_W-2 -: EXP_W];
    assign mant = word[MAN_W-1:0];

    // Detect NaN and the signalling kind from exponent and mantissa fields.
    always_comb begin
        is_nan  = (&expo) && (|mant);
        is_snan = is_nan && !mant[MAN_W-1];
    end

endmodule

// File: rtl/fcmp_order.sv
// Orders two non-NaN packed words by their bit patterns: sign first, then the
// magnitude integer, reversed when both are negative. Both zeros compare equal.
module fcmp_order #(
    parameter int WORD_W = 32,
    localparam int MAG_W = WORD_W - 1
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              a_eq_b,
    output logic              a_lt_b
);

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             sign_a;
    logic             sign_b;
    logic             mag_below;
    logic             mag_above;

    assign mag_a  = a[MAG_W-1:0];
    assign mag_b  = b[MAG_W-1:0];
    assign sign_a = a[WORD_W-1];
    assign sign_b = b[WORD_W-1];

    // Magnitude comparisons shared by both sign cases.
    always_comb begin
        mag_below = mag_a < mag_b;
        mag_above = mag_a > mag_b;
    end

    // Equality with the signed-zero rule, then the signed ordering.
    always_comb begin
        a_eq_b = (a == b) || ((mag_a | mag_b) == '0);
        if (sign_a != sign_b)
            a_lt_b = sign_a;
        else if (sign_a)
            a_lt_b = mag_above;
        else
            a_lt_b = mag_below;
    end

endmodule

// File: rtl/fcmp_nzcv.sv
// Single-precision compare producing registered N,Z,C,V and invalid flags.
// Assumes operands are held for the edge that samples them; one-cycle latency.
// quiet_traps makes quiet NaNs trap; cmp_zero substitutes +0 for op_m.
module fcmp_nzcv
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int N_OPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_d,
    input  logic [WORD_W-1:0] op_m,
    input  logic              quiet_traps,
    input  logic              cmp_zero,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              invalid
);

    logic [WORD_W-1:0] opnd [N_OPS];
    logic [N_OPS-1:0]  nan_hit;
    logic [N_OPS-1:0]  snan_hit;
    logic              d_eq_m;
    logic              d_lt_m;
    logic              trap_next;
    nzcv_t             flags_next;
    nzcv_t             flags_q;
    logic              invalid_q;

    // Select the second operand: +0 in compare-with-zero mode.
    always_comb begin
        opnd[0] = op_d;
        opnd[1] = cmp_zero ? '0 : op_m;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_cls
            fcmp_class #(
                .EXP_W (EXP_W),
                .MAN_W (MAN_W)
            ) u_cls (
                .word    (opnd[gi]),
                .is_nan  (nan_hit[gi]),
                .is_snan (snan_hit[gi])
            );
        end
    endgenerate

    fcmp_order #(
        .WORD_W (WORD_W)
    ) u_order (
        .a      (opnd[0]),
        .b      (opnd[1]),
        .a_eq_b (d_eq_m),
        .a_lt_b (d_lt_m)
    );

    // Pick the flag pattern: unordered first, then equal, less, greater.
    always_comb begin
        trap_next = |(nan_hit & (snan_hit | {N_OPS{quiet_traps}}));
        if (|nan_hit)
            flags_next = FLG_UNORD;
        else if (d_eq_m)
            flags_next = FLG_EQUAL;
        else if (d_lt_m)
            flags_next = FLG_LESS;
        else
            flags_next = FLG_GREATER;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            invalid_q <= 1'b0;
        end else begin
            flags_q   <= flags_next;
            invalid_q <= trap_next;
        end
    end

    assign flag_n  = flags_q.n;
    assign flag_z  = flags_q.z;
    assign flag_c  = flags_q.c;
    assign flag_v  = flags_q.v;
    assign invalid = invalid_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c, flag_v, invalid} == 5'b0));

    // R3
    nan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nan_hit) |=> (flag_c && flag_v && !flag_n && !flag_z));

    // R4
    snan_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|snan_hit) |=> invalid);

    // R5
    quiet_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet_traps && !(|snan_hit)) |=> !invalid);

    // R6
    clean_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|nan_hit) |=> (!invalid && !flag_v));

    // R12
    one_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0110 ||
                  {flag_n, flag_z, flag_c, flag_v} == 4'b1000 ||
                  {flag_n, flag_z, flag_c, flag_v} == 4'b0010 ||
                  {flag_n, flag_z, flag_c, flag_v} == 4'b0011));

endmodule

// File: tb/test_fcmp_nzcv.sv
module test_fcmp_nzcv;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_d;
    logic [31:0] op_m;
    logic        quiet_traps;
    logic        cmp_zero;
    logic        flag_n, flag_z, flag_c, flag_v, invalid;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [4:0] f;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    fcmp_nzcv i_fcmp_nzcv (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_d        (op_d),
        .op_m        (op_m),
        .quiet_traps (quiet_traps),
        .cmp_zero    (cmp_zero),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .flag_v      (flag_v),
        .invalid     (invalid)
    );

    // Expected {N,Z,C,V,invalid} built from the requirements (signed-magnitude keys).
    function automatic logic [4:0] model(input logic [31:0] d, input logic [31:0] m,
                                         input logic qt, input logic cz);
        logic [31:0] mm;
        logic        dn, mn, inv;
        longint      kd, km;
        mm = cz ? 32'h0 : m;
        dn = (d[30:23] == 8'hFF) && (d[22:0] != 0);
        mn = (mm[30:23] == 8'hFF) && (mm[22:0] != 0);
        if (dn || mn) begin
            inv = (dn && (qt || !d[22])) || (mn && (qt || !mm[22]));
            return {4'b0011, inv};
        end
        kd = d[31] ? -longint'(d[30:0]) : longint'(d[30:0]);
        km = mm[31] ? -longint'(mm[30:0]) : longint'(mm[30:0]);
        if (kd == km) return 5'b01100;
        if (kd < km)  return 5'b10000;
        return 5'b00100;
    endfunction

    task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got NZCV+inv=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [31:0] d, input logic [31:0] m,
                         input logic qt, input logic cz, input string tag);
        exp_t e;
        @(negedge clk);
        op_d        = d;
        op_m        = m;
        quiet_traps = qt;
        cmp_zero    = cz;
        e.f   = model(d, m, qt, cz);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare registered outputs a quarter period after each edge.
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (rst_n && sb.size() > 0) begin
            e = sb.pop_front();
            check({flag_n, flag_z, flag_c, flag_v, invalid}, e.f, e.tag);
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_d = '0; op_m = '0; quiet_traps = 1'b0; cmp_zero = 1'b0;
        repeat (3) @(posedge clk);
        #5 check({flag_n, flag_z, flag_c, flag_v, invalid}, 5'b0, "R1 reset");
        @(negedge clk) rst_n = 1'b1;

        drive(32'h3F800000, 32'h40000000, 0, 0, "R9 pos less");
        drive(32'h40000000, 32'h3F800000, 0, 0, "R9 pos greater");
        drive(32'hBF800000, 32'hC0000000, 0, 0, "R9 neg greater");
        drive(32'hC0000000, 32'hBF800000, 0, 0, "R9 neg less");
        drive(32'h3F800000, 32'hBF800000, 0, 0, "R8 d positive");
        drive(32'hBF800000, 32'h3F800000, 0, 0, "R8 d negative");
        drive(32'h00000000, 32'h80000000, 0, 0, "R7 +0 vs -0");
        drive(32'h80000000, 32'h00000000, 1, 0, "R7 -0 vs +0");
        drive(32'h3F800000, 32'h3F800000, 0, 0, "R7 identical");
        drive(32'h7FC00000, 32'h3F800000, 0, 0, "R5 qnan d no trap");
        drive(32'h3F800000, 32'h7FC00000, 1, 0, "R5 qnan m trap");
        drive(32'h3F800000, 32'h7F800001, 0, 0, "R4 snan m");
        drive(32'hFFA00000, 32'h3F800000, 1, 0, "R4 snan d");
        drive(32'hFFC00000, 32'hFFC00000, 0, 0, "R3 both nan");
        drive(32'h7F800000, 32'h7F7FFFFF, 0, 0, "R10 +inf above max");
        drive(32'hFF800000, 32'hFF7FFFFF, 0, 0, "R10 -inf below min");
        drive(32'h7F800000, 32'h7F800000, 0, 0, "R10 inf equal");
        drive(32'h00000001, 32'h00000000, 0, 0, "R9 denormal above zero");
        drive(32'h80000000, 32'h7FC00000, 0, 1, "R11 zero mode ignores m nan");
        drive(32'h3F800000, 32'h7F000000, 1, 1, "R11 zero mode greater");
        drive(32'hBF800000, 32'h00000000, 0, 1, "R11 zero mode less");
        drive(32'h7FA00000, 32'h00000000, 0, 1, "R11 zero mode d snan");
        drive(32'h7FC00000, 32'h00000000, 1, 1, "R11 zero mode trap quiet");

        // R2: a new input must not reach the outputs before the next edge.
        wait (sb.size() == 0);
        drive(32'h40000000, 32'h3F800000, 0, 0, "R2 first");
        @(posedge clk);
        #6;
        drive(32'h3F800000, 32'h40000000, 0, 0, "R2 second");
        #5 check({flag_n, flag_z, flag_c, flag_v, invalid}, 5'b00100, "R2 hold before edge");

        // R12: mixed pseudo-random operands, biased toward special exponents.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rd, rm;
            rd = $urandom;
            rm = $urandom;
            if (k % 4 == 0) rd[30:23] = 8'hFF;
            if (k % 5 == 0) rm[30:23] = 8'hFF;
            if (k % 7 == 0) rm = rd ^ 32'h80000000;
            if (k % 11 == 0) rm = rd;
            drive(rd, rm, k[0], (k % 9 == 0), "R12 random");
        end

        // R1: reset in mid-run clears the outputs.
        wait (sb.size() == 0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #5 check({flag_n, flag_z, flag_c, flag_v, invalid}, 5'b0, "R1 mid-run reset");
        @(negedge clk) rst_n = 1'b1;

        repeat (2) @(posedge clk);
        #10;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule